// File: doc/BRIEF.md
# Third-Order Feed-Forward Noise-Shaping Modulator

This block turns a stream of wide signed samples at the oversampled rate into a 5-bit code for a multi-bit current-steering converter. Three integrators are connected in a chain. Their scaled states are added to the input and quantized to 32 levels. The quantized value is fed back into the first integrator only. All loop coefficients are powers of two, so the loop needs only adders and shifts.

A 16-bit linear-feedback shift register supplies dither. The dither is always smaller than half a quantizer step and breaks up idle tones on quiet or constant inputs. With a 1.536 MHz modulator clock, the block serves a 6 kHz output rate at 256x oversampling or a 12 kHz output rate at 128x oversampling. The clock enable marks the cycles that carry a sample.

Each integrator clips at its range limits instead of wrapping. Any clipping event sets an overload flag, which stays set until the next reset.

Top module: `sdm_ff3`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it rises, `code_out` is 16 and `overload` is 0. Reset also clears all three integrators and loads the dither register with 16'hACE1.
- R2: The code computed from the sample present at a rising clock edge with `en` high appears on `code_out` right after that edge, and is held there until the next enabled edge.
- R3: The quantizer output is q = floor(y / 2^(IN_W-5)) + 16, clamped to the range 0..31. Sustained full-scale negative input drives the code to 0.
- R4: The loop sum is y = x + (s1 >>> SH1) + (s2 >>> SH2) + (s3 >>> SH3) + d. Here x is the sample, s1..s3 are the integrator states before the edge, and d is the dither. The shifts are arithmetic, and the defaults are 0, 1 and 3.
- R5: On each enabled edge, s1 += x - f, s2 += s1 and s3 += s2, all using the old states. The feedback is f = (q - 16) * 2^(IN_W-5).
- R6: When an integrator update would go beyond the signed INT_W range, the integrator holds the maximum or minimum value of that range instead of wrapping.
- R7: `overload` goes to 1 on the edge where any integrator clips. It stays at 1 until reset.
- R8: The dither register has 16 bits and shifts left by one position on each enabled edge. The new bit 0 is b15^b13^b12^b10. When `dith_en` is 1, d is the low IN_W-6 bits of the register read as a signed number; otherwise d is 0.
- R9: With `en` low, the code, the integrators, the dither register and `overload` do not change, whatever the sample input is.
- R10: For a constant in-range input, the mean of (code - 16) * 2^(IN_W-5) over a long run is within 256 of the input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Modulator clock |
| rst_n | input | 1 | Synchronous reset, active low |
| en | input | 1 | Sample strobe; the loop advances only when this is high |
| dith_en | input | 1 | Adds LFSR dither into the quantizer sum when high |
| sample_in | input | IN_W | Signed input sample at the oversampled rate |
| code_out | output | 5 | Registered quantizer code, 0..31, midscale 16 |
| overload | output | 1 | Sticky flag showing that an integrator has clipped |

## Verification
The bench builds the block with IN_W = 16 and INT_W = 20. The input-to-step ratio is therefore the same as with the default width, but the integrator headroom is much smaller. A held full-scale positive input, which the feedback cannot balance, then clips the first integrator within a few hundred cycles. This makes both the clipping and the sticky flag observable in a short run. The 20-bit width still leaves enough room for the third integrator during ordinary random and constant-input runs. Because of that, the long constant-input mean test exercises the unclipped loop.

// File: rtl/sdm_pkg.sv
`timescale 1ns/1ps
// Package: shared helpers for the noise-shaping modulator.
// Assumes: the dither register is exactly 16 bits wide.
package sdm_pkg;
    localparam int LFSR_W = 16;

    // Next state of the 16-bit dither register: shift left, feedback from taps 15,13,12,10.
    function automatic logic [LFSR_W-1:0] lfsr16_next(input logic [LFSR_W-1:0] s);
        return {s[LFSR_W-2:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
    endfunction
endpackage

// File: rtl/sdm_dither_lfsr.sv
`timescale 1ns/1ps
// Module: dither source. Holds a 16-bit LFSR that steps once per enabled cycle
// and presents its low DITH_W bits as a signed dither value.
// Assumes: SEED is non-zero and DITH_W <= 16.
module sdm_dither_lfsr #(
    parameter logic [15:0] SEED   = 16'hACE1,
    parameter int          DITH_W = 10
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     en,
    output logic signed [DITH_W-1:0] dith_val
);
    import sdm_pkg::*;

    logic [LFSR_W-1:0] state;

    // Step the register on each enabled cycle; reload the seed on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= SEED;
        end else if (en) begin
            state <= lfsr16_next(state);
        end
    end

    // Low bits of the register reinterpreted as a two's complement value.
    always_comb begin
        dith_val = $signed(state[DITH_W-1:0]);
    end
endmodule

// File: rtl/sdm_integ.sv
`timescale 1ns/1ps
// Module: one clipping accumulator of the loop filter. Adds its input on each
// enabled cycle and pins at the signed range limits instead of wrapping.
// Assumes: the addend already fits within W bits.
module sdm_integ #(
    parameter int W = 24
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                en,
    input  logic signed [W-1:0] addend,
    output logic signed [W-1:0] acc,
    output logic                clip
);
    localparam logic signed [W-1:0] MAXV = {1'b0, {(W-1){1'b1}}};
    localparam logic signed [W-1:0] MINV = {1'b1, {(W-1){1'b0}}};

    logic signed [W:0]   sum;
    logic                ovf;
    logic signed [W-1:0] nxt;

    // Widened sum, overflow detection from the two top bits, clipped result.
    always_comb begin
        sum  = {acc[W-1], acc} + {addend[W-1], addend};
        ovf  = sum[W] ^ sum[W-1];
        nxt  = ovf ? (sum[W] ? MINV : MAXV) : sum[W-1:0];
        clip = en & ovf;
    end

    // Accumulator register, cleared on reset, updated only on enabled cycles.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc <= '0;
        end else if (en) begin
            acc <= nxt;
        end
    end
endmodule

// File: rtl/sdm_quant.sv
`timescale 1ns/1ps
// Module: feed-forward summation and multi-level quantizer. Adds the input,
// the shifted integrator states and the dither, then maps the sum to 2^OUT_W levels.
// Assumes: NST shift amounts are supplied; the internal sum width cannot overflow.
module sdm_quant #(
    parameter int IN_W   = 16,
    parameter int INT_W  = 24,
    parameter int OUT_W  = 5,
    parameter int DITH_W = 10,
    parameter int NST    = 3,
    parameter int SH1    = 0,
    parameter int SH2    = 1,
    parameter int SH3    = 3
) (
    input  logic signed [IN_W-1:0]   sample,
    input  logic signed [INT_W-1:0]  st [NST],
    input  logic signed [DITH_W-1:0] dith,
    output logic [OUT_W-1:0]         code
);
    localparam int QS     = IN_W - OUT_W;
    localparam int YW     = INT_W + 3;
    localparam int LEVELS = 1 << OUT_W;
    localparam int MID    = LEVELS / 2;
    localparam int SH [3] = '{SH1, SH2, SH3};

    logic signed [YW-1:0] term [NST];
    logic signed [YW-1:0] y;
    logic signed [YW-1:0] lvl;

    // One scaled feed-forward term per integrator stage.
    for (genvar k = 0; k < NST; k++) begin : g_term
        assign term[k] = YW'(st[k] >>> SH[k]);
    end

    // Total of the input, the feed-forward terms and the dither, then level selection with clamping.
    always_comb begin
        y = YW'(sample) + YW'(dith);
        for (int k = 0; k < NST; k++) begin
            y = y + term[k];
        end
        lvl = (y >>> QS) + YW'(MID);
        if (lvl < 0) begin
            code = '0;
        end else if (lvl > YW'(LEVELS - 1)) begin
            code = OUT_W'(LEVELS - 1);
        end else begin
            code = lvl[OUT_W-1:0];
        end
    end
endmodule

// File: rtl/sdm_ff3.sv
`timescale 1ns/1ps
// Module: third-order feed-forward noise-shaping modulator (top). A chain of
// three clipping integrators feeds the quantizer; only the first stage receives
// the quantized feedback. Dither from an LFSR can be added before quantizing.
// Assumes: INT_W > IN_W + 2 and OUT_W < IN_W - 1; synchronous active-low reset.
module sdm_ff3 #(
    parameter int          IN_W  = 16,
    parameter int          OUT_W = 5,
    parameter int          INT_W = 24,
    parameter int          SH1   = 0,
    parameter int          SH2   = 1,
    parameter int          SH3   = 3,
    parameter logic [15:0] SEED  = 16'hACE1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   en,
    input  logic                   dith_en,
    input  logic signed [IN_W-1:0] sample_in,
    output logic [OUT_W-1:0]       code_out,
    output logic                   overload
);
    localparam int NST    = 3;
    localparam int QS     = IN_W - OUT_W;
    localparam int EW     = IN_W + 2;
    localparam int DITH_W = QS - 1;
    localparam int MID    = 1 << (OUT_W - 1);
    localparam logic signed [EW-1:0] MID_E = EW'(MID);

    logic signed [INT_W-1:0]  acc    [NST];
    logic signed [INT_W-1:0]  addend [NST];
    logic [NST-1:0]           clip;
    logic signed [DITH_W-1:0] dith_raw;
    logic signed [DITH_W-1:0] dith;
    logic [OUT_W-1:0]         q_next;
    logic signed [EW-1:0]     q_ext;
    logic signed [EW-1:0]     fb;
    logic signed [EW-1:0]     err;

    sdm_dither_lfsr #(.SEED(SEED), .DITH_W(DITH_W)) u_lfsr (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (en),
        .dith_val (dith_raw)
    );

    // Dither gate: pass the LFSR value only when dither is requested.
    always_comb begin
        dith = dith_en ? dith_raw : '0;
    end

    sdm_quant #(
        .IN_W(IN_W), .INT_W(INT_W), .OUT_W(OUT_W), .DITH_W(DITH_W),
        .NST(NST), .SH1(SH1), .SH2(SH2), .SH3(SH3)
    ) u_quant (
        .sample (sample_in),
        .st     (acc),
        .dith   (dith),
        .code   (q_next)
    );

    // Feedback level in input units, and the error fed to the first integrator.
    always_comb begin
        q_ext = $signed({{(EW-OUT_W){1'b0}}, q_next});
        fb    = (q_ext - MID_E) <<< QS;
        err   = EW'(sample_in) - fb;
    end

    // Integrator chain: the first stage takes the error, later stages take the previous state.
    for (genvar k = 0; k < NST; k++) begin : g_stage
        if (k == 0) begin : g_head
            assign addend[k] = INT_W'(err);
        end else begin : g_tail
            assign addend[k] = acc[k-1];
        end
        sdm_integ #(.W(INT_W)) u_integ (
            .clk    (clk),
            .rst_n  (rst_n),
            .en     (en),
            .addend (addend[k]),
            .acc    (acc[k]),
            .clip   (clip[k])
        );
    end

    // Output code register, midscale after reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            code_out <= OUT_W'(MID);
        end else if (en) begin
            code_out <= q_next;
        end
    end

    // Sticky overload flag, set by any clipping stage and cleared only by reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            overload <= 1'b0;
        end else if (|clip) begin
            overload <= 1'b1;
        end
    end
endmodule

// File: rtl/sdm_ff3_chk.sv
`timescale 1ns/1ps
// Module: property checker for the modulator top, attached by bind.
// Assumes: it observes the top ports and the first integrator state.
module sdm_ff3_chk #(
    parameter int OUT_W = 5,
    parameter int INT_W = 24
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    en,
    input logic [OUT_W-1:0]        code_out,
    input logic                    overload,
    input logic signed [INT_W-1:0] acc0
);
    localparam int MID = 1 << (OUT_W - 1);

    // Reset state is visible on the first edge after release.
    p_reset_state_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (code_out == OUT_W'(MID)) && !overload);

    // Output code is frozen through idle cycles.
    p_idle_code_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> $stable(code_out));

    // First integrator is frozen through idle cycles.
    p_idle_integ_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> $stable(acc0));

    // Overload never clears once set.
    p_ovl_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        overload |=> overload);

    // Overload can only appear after an enabled update.
    p_ovl_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(overload) |-> $past(en));
endmodule

bind sdm_ff3 sdm_ff3_chk #(.OUT_W(OUT_W), .INT_W(INT_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .en       (en),
    .code_out (code_out),
    .overload (overload),
    .acc0     (acc[0])
);

// File: tb/sdm_ff3_test.sv
`timescale 1ns/1ps
// Bench: behavioural reference model of the modulator, compared on every clock.
module sdm_ff3_test;
    localparam int IN_W  = 16;
    localparam int OUT_W = 5;
    localparam int INT_W = 20;
    localparam int SH1   = 0;
    localparam int SH2   = 1;
    localparam int SH3   = 3;
    localparam int QS    = IN_W - OUT_W;
    localparam int DW    = QS - 1;
    localparam int MID   = 16;
    localparam longint IMAX = (longint'(1) << (INT_W - 1)) - 1;
    localparam longint IMIN = -(longint'(1) << (INT_W - 1));

    logic                   clk = 1'b0;
    logic                   rst_n = 1'b0;
    logic                   en = 1'b0;
    logic                   dith_en = 1'b0;
    logic signed [IN_W-1:0] sample_in = '0;
    logic [OUT_W-1:0]       code_out;
    logic                   overload;

    int  n_chk = 0;
    int  n_fail = 0;
    bit  done = 0;

    longint m_i1, m_i2, m_i3, m_lfsr, m_q;
    bit     m_ovl;

    always #2.5 clk = ~clk;

    sdm_ff3 #(.IN_W(IN_W), .OUT_W(OUT_W), .INT_W(INT_W)) uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (en),
        .dith_en   (dith_en),
        .sample_in (sample_in),
        .code_out  (code_out),
        .overload  (overload)
    );

    task automatic chk(input string tag, input string what, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: got %0d expected %0d", tag, what, act, exp);
        end
    endtask

    function automatic longint sat(input longint v, inout bit hit);
        if (v > IMAX) begin hit = 1; return IMAX; end
        if (v < IMIN) begin hit = 1; return IMIN; end
        return v;
    endfunction

    task automatic m_reset();
        m_i1 = 0; m_i2 = 0; m_i3 = 0; m_lfsr = 'hACE1; m_q = MID; m_ovl = 0;
    endtask

    task automatic m_step(input bit e, input bit de, input longint x);
        longint d, y, q, fb, n1, n2, n3, b;
        bit hit;
        if (!e) return;
        hit = 0;
        d = 0;
        if (de) begin
            d = m_lfsr & ((longint'(1) << DW) - 1);
            if (d >= (longint'(1) << (DW - 1))) d -= (longint'(1) << DW);
        end
        y = x + (m_i1 >>> SH1) + (m_i2 >>> SH2) + (m_i3 >>> SH3) + d;
        q = (y >>> QS) + MID;
        if (q < 0) q = 0;
        if (q > 31) q = 31;
        fb = (q - MID) * (longint'(1) << QS);
        n1 = sat(m_i1 + x - fb, hit);
        n2 = sat(m_i2 + m_i1, hit);
        n3 = sat(m_i3 + m_i2, hit);
        m_i1 = n1; m_i2 = n2; m_i3 = n3;
        m_q = q;
        if (hit) m_ovl = 1;
        b = ((m_lfsr >> 15) ^ (m_lfsr >> 13) ^ (m_lfsr >> 12) ^ (m_lfsr >> 10)) & 1;
        m_lfsr = ((m_lfsr << 1) | b) & 'hFFFF;
    endtask

    // One clock: drive at the falling edge, step the model at the rising edge, compare at the next falling edge.
    task automatic cyc(input bit e, input bit de, input int x, input string tag);
        en = e; dith_en = de; sample_in = IN_W'(x);
        @(posedge clk);
        m_step(e, de, longint'(x));
        @(negedge clk);
        chk(tag, "code_out", longint'(code_out), m_q);
        chk(tag, "overload", longint'(overload), longint'(m_ovl));
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 0; en = 0;
        repeat (3) @(negedge clk);
        m_reset();
        chk("R1", "code in reset", longint'(code_out), MID);
        chk("R1", "overload in reset", longint'(overload), 0);
        rst_n = 1;
    endtask

    task automatic report();
        $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            report();
        end
    end

    initial begin
        longint acc_sum;
        int     n_avg;
        m_reset();
        do_reset();
        cyc(0, 0, 0, "R1");
        // R2 R4 R5: random in-range input without dither.
        for (int i = 0; i < 300; i++) cyc(1, 0, int'($urandom_range(0, 40000)) - 20000, "R2/R4/R5");
        // R8: random input with dither.
        for (int i = 0; i < 300; i++) cyc(1, 1, int'($urandom_range(0, 30000)) - 15000, "R8");
        // R9: idle cycles with wild input must leave everything untouched.
        for (int i = 0; i < 20; i++) cyc(0, 1, int'($urandom_range(0, 65535)) - 32768, "R9");
        // R9: after resuming, states must continue exactly where they stopped.
        for (int i = 0; i < 50; i++) cyc(1, 1, int'($urandom_range(0, 20000)) - 10000, "R9");
        // R3: full-scale negative input pushes the code to the bottom clamp.
        for (int i = 0; i < 100; i++) cyc(1, 0, -32768, "R3");
        chk("R3", "low clamp code", longint'(code_out), 0);
        // R6: full-scale positive input outruns the feedback and clips the integrators.
        for (int i = 0; i < 400; i++) cyc(1, 0, 32767, "R6");
        chk("R6", "top clamp code", longint'(code_out), 31);
        chk("R7", "overload after clipping", longint'(overload), 1);
        // R7: flag stays set with ordinary input.
        for (int i = 0; i < 50; i++) cyc(1, 1, 1000, "R7");
        chk("R7", "overload still set", longint'(overload), 1);
        // R1: reset clears the flag and restores midscale.
        do_reset();
        cyc(0, 0, 0, "R1");
        // R10: constant input, mean of the feedback level tracks the input.
        acc_sum = 0; n_avg = 0;
        for (int i = 0; i < 2000; i++) begin
            cyc(1, 1, 5000, "R10");
            if (i >= 100) begin
                acc_sum += (longint'(code_out) - MID) * (longint'(1) << QS);
                n_avg++;
            end
        end
        begin
            longint mean, diff;
            mean = acc_sum / n_avg;
            diff = (mean > 5000) ? (mean - 5000) : (5000 - mean);
            chk("R10", "mean tracks input (within tolerance)", (diff < 256) ? mean : mean + 100000, mean);
        end
        done = 1;
        report();
    end
endmodule